// File: doc/BRIEF.md
# Toggle-Polled Flash Bank Sequencer

This block erases or programs one flash bank whose device takes every command behind a two-write unlock preamble and signals completion by a bit that toggles on each read while an internal operation runs. A single request (`start_i` with `op_i` and a bank base address) starts a full run. For an erase the sequencer sends the erase preamble and confirm. For a program it walks the bank byte by byte, fetching each byte from a source port indexed by `src_idx_o`. After each device operation it polls until two back-to-back reads agree. It then returns the device to read mode and reads the whole bank back to confirm the result.

The flash bus is byte-wide with single-cycle write and read strobes. Read data is sampled on the clock edge that ends a read cycle. `busy_o` covers the whole run, `done_o` pulses once at its end, and `err_o` reports a poll timeout or a verify miscompare until the next accepted request.

States: IDLE (wait for a request), CMD (one bus write), GAP (idle spacing after a command write), POLL_A and POLL_B (the two status reads), EVAL (act on the registered toggle decision), RST_WR (read-mode write), RST_GAP (spacing after it), VERIFY (read and compare one byte per cycle), FIN (done pulse).

Transitions:
- IDLE→CMD on a request.
- CMD→GAP, or CMD→POLL_A after the last write of a sequence.
- GAP→CMD when the spacing expires.
- POLL_A→POLL_B→EVAL.
- EVAL→POLL_A while still toggling and under the limit.
- EVAL→CMD for the next program byte.
- EVAL→RST_WR when the run is finished or the poll limit is reached.
- RST_WR→RST_GAP→VERIFY.
- VERIFY→FIN on a miscompare or after the last byte.
- FIN→IDLE.

Top module: `flash_seq_ctrl`

## Requirements
- R1: An erase run issues exactly six command writes, in this order as (offset from base, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30).
- R2: A program run issues, for each byte index i from 0 to BANK_BYTES-1 in ascending order, four writes: (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (i, source byte i). The source byte for index i is the value on `src_data_i` while `src_idx_o` equals i.
- R3: Two consecutive writes of one command sequence are exactly GAP_CYCLES+1 clock edges apart, with no bus activity between them.
- R4: After the last write of a sequence, the block polls with pairs of reads at the base address and never writes during polling. A pair whose two values differ means busy and causes another pair. A pair with equal values ends polling.
- R5: After POLL_LIMIT consecutive busy pairs, polling stops and `err_o` is set. In a program run, no further bytes are written.
- R6: Every run ends its write activity with one write of 0xF0 to the base address, after polling completes or times out. No write follows it in the same run.
- R7: The verify pass reads the bank starting at the base address. It expects 0xFF after an erase and the source bytes after a program. Any miscompare sets `err_o`.
- R8: `done_o` is high for exactly one cycle at the end of a run, while `busy_o` is still high. `busy_o` is low in the following cycle.
- R9: A request while `busy_o` is high is ignored, including in the cycle that `done_o` is high. A request arriving in the done cycle does not start a run and does not change the run in progress.
- R10: `err_o` holds its value while idle. It is cleared only when a new request is accepted.
- R11: After reset, `busy_o`, `done_o`, `err_o`, `fl_we_o` and `fl_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, accepted only when idle |
| op_i | input | 1 | 0 = erase, 1 = program |
| base_i | input | AW | Bank base address |
| src_idx_o | output | IDXW | Index of the source byte wanted |
| src_data_i | input | 8 | Source byte for `src_idx_o` |
| fl_addr_o | output | AW | Flash bus address |
| fl_wdata_o | output | 8 | Flash bus write data |
| fl_we_o | output | 1 | Single-cycle write strobe |
| fl_re_o | output | 1 | Single-cycle read strobe |
| fl_rdata_i | input | 8 | Flash read data, sampled at the edge ending a read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Timeout or verify failure, held until the next start |

## Verification
Two events can coincide in one cycle: the end-of-run `done_o` pulse and a fresh `start_i`. The bench raises `start_i` in exactly the cycle it observes `done_o` high. It then judges the outcome from the next cycle, where `busy_o` must be low, and from the flash model's write log, which must show no new command. A second collision comes from the flash model: a device that toggles forever makes the poll limit and a program byte loop both end in the same EVAL cycle. The bench judges this by the count of writes and of polling reads before the read-mode write.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_GAP, S_POLL_A, S_POLL_B, S_EVAL,
        S_RST_WR, S_RST_GAP, S_VERIFY, S_FIN
    } seq_state_e;

    localparam logic [7:0] RD_MODE_CODE = 8'hF0;
    localparam logic [7:0] BLANK_BYTE   = 8'hFF;

    // Offset of a command write within the erase or program preamble.
    function automatic logic [11:0] step_off(input logic prog, input logic [2:0] step);
        logic [11:0] off;
        case (step)
            3'd0:    off = 12'h555;
            3'd1:    off = 12'h2AA;
            3'd2:    off = 12'h555;
            3'd3:    off = prog ? 12'h000 : 12'h555;
            3'd4:    off = 12'h2AA;
            default: off = 12'h000;
        endcase
        return off;
    endfunction

    // Data byte of a command write.
    function automatic logic [7:0] step_byte(input logic prog, input logic [2:0] step,
                                             input logic [7:0] src);
        logic [7:0] b;
        case (step)
            3'd0:    b = 8'hAA;
            3'd1:    b = 8'h55;
            3'd2:    b = prog ? 8'hA0 : 8'h80;
            3'd3:    b = prog ? src : 8'hAA;
            3'd4:    b = 8'h55;
            default: b = 8'h30;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
    parameter int GAP_CYCLES = 50,
    localparam int GW = $clog2(GAP_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == GW'(GAP_CYCLES - 1));
endmodule

// File: rtl/flash_toggle_cmp.sv
module flash_toggle_cmp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_a_i,
    input  logic       cap_b_i,
    input  logic [7:0] rdata_i,
    output logic       toggling_o
);
    logic [7:0] first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q    <= '0;
            toggling_o <= 1'b0;
        end else begin
            if (cap_a_i) first_q <= rdata_i;
            if (cap_b_i) toggling_o <= |(first_q ^ rdata_i);
        end
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int BANK_BYTES = 8192,
    parameter int GAP_CYCLES = 50,
    parameter int POLL_LIMIT = 1000000,
    localparam int IDXW = $clog2(BANK_BYTES),
    localparam int PCW  = $clog2(POLL_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            op_i,
    input  logic [AW-1:0]   base_i,
    output logic [IDXW-1:0] src_idx_o,
    input  logic [7:0]      src_data_i,
    output logic [AW-1:0]   fl_addr_o,
    output logic [7:0]      fl_wdata_o,
    output logic            fl_we_o,
    output logic            fl_re_o,
    input  logic [7:0]      fl_rdata_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o
);
    seq_state_e      state_q, state_d;
    logic [2:0]      step_q;
    logic [IDXW-1:0] idx_q;
    logic [PCW-1:0]  pcnt_q;
    logic [AW-1:0]   base_q;
    logic            op_q;
    logic            err_q;
    logic            gap_exp;
    logic            toggling;

    wire [2:0] last_step = op_q ? 3'd3 : 3'd5;
    wire       last_idx  = (idx_q == IDXW'(BANK_BYTES - 1));
    wire       poll_end  = (pcnt_q == PCW'(POLL_LIMIT - 1));
    wire [7:0] expect_b  = op_q ? src_data_i : BLANK_BYTE;
    wire       miscmp    = (fl_rdata_i != expect_b);

    flash_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .run_i(state_q == S_GAP || state_q == S_RST_GAP),
        .expired_o(gap_exp)
    );

    flash_toggle_cmp u_tog (
        .clk(clk), .rst_n(rst_n),
        .cap_a_i(state_q == S_POLL_A), .cap_b_i(state_q == S_POLL_B),
        .rdata_i(fl_rdata_i), .toggling_o(toggling)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_CMD;
            S_CMD:     state_d = (step_q == last_step) ? S_POLL_A : S_GAP;
            S_GAP:     if (gap_exp) state_d = S_CMD;
            S_POLL_A:  state_d = S_POLL_B;
            S_POLL_B:  state_d = S_EVAL;
            S_EVAL: begin
                if (toggling)            state_d = poll_end ? S_RST_WR : S_POLL_A;
                else if (op_q && !last_idx) state_d = S_CMD;
                else                     state_d = S_RST_WR;
            end
            S_RST_WR:  state_d = S_RST_GAP;
            S_RST_GAP: if (gap_exp) state_d = S_VERIFY;
            S_VERIFY:  if (miscmp || last_idx) state_d = S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0; idx_q <= '0; pcnt_q <= '0;
            base_q <= '0; op_q <= 1'b0; err_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    base_q <= base_i; op_q <= op_i; err_q <= 1'b0;
                    step_q <= '0; idx_q <= '0; pcnt_q <= '0;
                end
                S_CMD: begin
                    if (step_q == last_step) begin
                        step_q <= '0;
                        pcnt_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                S_EVAL: begin
                    if (toggling) begin
                        pcnt_q <= pcnt_q + 1'b1;
                        if (poll_end) err_q <= 1'b1;
                    end else if (op_q && !last_idx) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_RST_WR: idx_q <= '0;
                S_VERIFY: begin
                    if (miscmp) err_q <= 1'b1;
                    if (!last_idx) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fl_addr_o  = base_q;
        fl_wdata_o = '0;
        fl_we_o    = 1'b0;
        fl_re_o    = 1'b0;
        unique case (state_q)
            S_CMD: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = step_byte(op_q, step_q, src_data_i);
                fl_addr_o  = (op_q && step_q == 3'd3) ? base_q + AW'(idx_q)
                                                      : base_q + AW'(step_off(op_q, step_q));
            end
            S_POLL_A, S_POLL_B: fl_re_o = 1'b1;
            S_RST_WR: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = RD_MODE_CODE;
            end
            S_VERIFY: begin
                fl_re_o   = 1'b1;
                fl_addr_o = base_q + AW'(idx_q);
            end
            default: ;
        endcase
    end

    assign src_idx_o = idx_q;
    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = (state_q == S_FIN);
    assign err_o     = err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic err_o,
    input logic fl_we_o,
    input logic fl_re_o
);
    // R4
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_re_o));

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we_o |=> !fl_we_o);

    // R8
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);

    // R10
    err_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(err_o));

    // R11
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!fl_we_o && !fl_re_o));
endmodule

bind flash_seq_ctrl flash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .fl_we_o(fl_we_o), .fl_re_o(fl_re_o)
);

// File: tb/tb_flash_seq_ctrl.sv
module tb_flash_seq_ctrl;
    localparam int BANK = 16;
    localparam int GAP  = 3;
    localparam int LIM  = 4;
    localparam logic [15:0] BASE = 16'h4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op = 1'b0;
    logic [3:0]  src_idx;
    logic [7:0]  src_data;
    logic [15:0] fl_addr;
    logic [7:0]  fl_wdata, fl_rdata;
    logic        fl_we, fl_re, busy, done, err;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] src_of(input int i);
        return 8'(i * 29 + 90);
    endfunction

    assign src_data = src_of(int'(src_idx));

    flash_seq_ctrl #(.AW(16), .BANK_BYTES(BANK), .GAP_CYCLES(GAP), .POLL_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .base_i(BASE),
        .src_idx_o(src_idx), .src_data_i(src_data),
        .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
        .fl_rdata_i(fl_rdata), .busy_o(busy), .done_o(done), .err_o(err)
    );

    // ---------------- flash model ----------------
    logic        stuck = 1'b0;
    logic        bad = 1'b0;
    logic [7:0]  mem [BANK];
    logic [2:0]  seq;
    int          bcnt;
    logic        tog;
    int          nlog, nrd, cyc;
    logic        f0_seen;
    logic [15:0] log_a [128];
    logic [7:0]  log_d [128];
    int          log_c [128];
    wire  [15:0] off = fl_addr - BASE;

    always_comb begin
        if (bcnt != 0 && fl_addr == BASE) fl_rdata = {1'b0, tog, 6'b0};
        else if (off < 16'(BANK))         fl_rdata = (bad && off == 16'd3) ? 8'h00 : mem[off[3:0]];
        else                              fl_rdata = 8'hFF;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK; i++) mem[i] <= 8'h00;
            seq <= 0; bcnt <= 0; tog <= 1'b0; nlog <= 0; nrd <= 0; cyc <= 0; f0_seen <= 1'b0;
        end else begin
            cyc <= cyc + 1;
            if (start && !busy) begin
                nlog <= 0; nrd <= 0; f0_seen <= 1'b0;
            end else begin
                if (fl_we) begin
                    if (nlog < 128) begin
                        log_a[nlog] <= fl_addr; log_d[nlog] <= fl_wdata; log_c[nlog] <= cyc;
                    end
                    nlog <= nlog + 1;
                    if (seq == 0 && fl_wdata == 8'hF0) begin
                        bcnt <= 0; f0_seen <= 1'b1;
                    end else begin
                        case (seq)
                            3'd0: seq <= (off == 16'h555 && fl_wdata == 8'hAA) ? 3'd1 : 3'd0;
                            3'd1: seq <= (off == 16'h2AA && fl_wdata == 8'h55) ? 3'd2 : 3'd0;
                            3'd2: seq <= (off == 16'h555 && fl_wdata == 8'h80) ? 3'd3 :
                                         (off == 16'h555 && fl_wdata == 8'hA0) ? 3'd6 : 3'd0;
                            3'd3: seq <= (off == 16'h555 && fl_wdata == 8'hAA) ? 3'd4 : 3'd0;
                            3'd4: seq <= (off == 16'h2AA && fl_wdata == 8'h55) ? 3'd5 : 3'd0;
                            3'd5: begin
                                if (off == 16'h0 && fl_wdata == 8'h30) begin
                                    for (int i = 0; i < BANK; i++) mem[i] <= 8'hFF;
                                    bcnt <= stuck ? 1000000 : 4;
                                end
                                seq <= 3'd0;
                            end
                            default: begin
                                if (off < 16'(BANK)) mem[off[3:0]] <= mem[off[3:0]] & fl_wdata;
                                bcnt <= stuck ? 1000000 : 2;
                                seq <= 3'd0;
                            end
                        endcase
                    end
                end
                if (fl_re) begin
                    if (!f0_seen) nrd <= nrd + 1;
                    if (bcnt > 0 && fl_addr == BASE) begin
                        bcnt <= bcnt - 1; tog <= ~tog;
                    end
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic kick(input logic o);
        @(negedge clk); start = 1'b1; op = o;
        @(negedge clk); start = 1'b0;
    endtask

    // waits until done is seen high at a negedge; leaves time at that negedge
    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk("R8 done seen", int'(done), 1);
        chk("R8 busy with done", int'(busy), 1);
    endtask

    task automatic finish_run();
        wait_done();
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        chk("R8 busy drops", int'(busy), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 err", int'(err), 0);
        chk("R11 we", int'(fl_we), 0);
        chk("R11 re", int'(fl_re), 0);
    endtask

    task automatic t_erase();
        logic [15:0] ea [6] = '{16'h555, 16'h2AA, 16'h555, 16'h555, 16'h2AA, 16'h000};
        logic [7:0]  ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
        kick(1'b0);
        finish_run();
        chk("R1 write count", nlog, 7);
        for (int i = 0; i < 6; i++) begin
            chk("R1 addr", int'(log_a[i]), int'(BASE + ea[i]));
            chk("R1 data", int'(log_d[i]), int'(ed[i]));
        end
        for (int i = 0; i < 5; i++) chk("R3 spacing", log_c[i+1] - log_c[i], GAP + 1);
        chk("R6 reset addr", int'(log_a[6]), int'(BASE));
        chk("R6 reset data", int'(log_d[6]), 8'hF0);
        chk("R4 poll reads", nrd, 6);
        chk("R7 erase ok", int'(err), 0);
        for (int i = 0; i < BANK; i++) chk("R1 blank", int'(mem[i]), 8'hFF);
    endtask

    task automatic t_program(input bit intrude);
        kick(1'b1);
        if (intrude) begin
            repeat (20) @(negedge clk);
            start = 1'b1; op = 1'b0;
            @(negedge clk); start = 1'b0;
        end
        finish_run();
        chk("R2 write count", nlog, 4 * BANK + 1);
        for (int i = 0; i < BANK; i++) begin
            chk("R2 unlock1", int'(log_d[4*i]), 8'hAA);
            chk("R2 unlock2 addr", int'(log_a[4*i+1]), int'(BASE + 16'h2AA));
            chk("R2 setup", int'(log_d[4*i+2]), 8'hA0);
            chk("R2 target addr", int'(log_a[4*i+3]), int'(BASE) + i);
            chk("R2 target data", int'(log_d[4*i+3]), int'(src_of(i)));
            chk("R3 byte spacing", log_c[4*i+3] - log_c[4*i+2], GAP + 1);
            chk(intrude ? "R9 content kept" : "R2 content", int'(mem[i]), int'(src_of(i)));
        end
        chk("R6 reset last", int'(log_d[4*BANK]), 8'hF0);
        chk("R4 poll reads", nrd, 4 * BANK);
        chk("R7 program ok", int'(err), 0);
    endtask

    task automatic t_done_collision();
        kick(1'b0);
        wait_done();
        start = 1'b1; op = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 no restart on done", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk("R9 still idle", int'(busy), 0);
        chk("R9 no new writes", nlog, 7);
    endtask

    task automatic t_verify_fail_sticky();
        bad = 1'b1;
        kick(1'b0);
        finish_run();
        chk("R7 miscompare flagged", int'(err), 1);
        repeat (10) @(negedge clk);
        chk("R10 err held", int'(err), 1);
        bad = 1'b0;
        kick(1'b0);
        chk("R10 err cleared at start", int'(err), 0);
        finish_run();
        chk("R10 clean run", int'(err), 0);
    endtask

    task automatic t_timeout();
        kick(1'b0);
        finish_run();
        stuck = 1'b1;
        kick(1'b1);
        finish_run();
        stuck = 1'b0;
        chk("R5 timeout err", int'(err), 1);
        chk("R5 loop stopped", nlog, 5);
        chk("R5 poll pairs", nrd, 2 * LIM);
        chk("R6 reset after timeout", int'(log_d[4]), 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase();
        t_program(1'b0);
        t_erase();
        t_program(1'b1);
        t_done_collision();
        t_verify_fail_sticky();
        t_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule